// File: doc/BRIEF.md
# SSI Absolute Position Reader

This block is the master side of a synchronous serial link to an absolute position encoder. A one-cycle start strobe launches a frame. The block then drives 25 clock pulses on the serial clock line. On the first 24 it reads a 24-bit position word, most significant bit first. It reads the 25th bit, the encoder's power-failure flag, and throws it away. When the Gray-select input is set at start, the incoming code is converted to plain binary while it is shifted in.

Once the last clock has ended, the serial clock stays high and the block checks the link. The data line must be low at a fixed delay after the final rising edge, given in microseconds. It must be high again at a second, longer delay. When the second check is done the block publishes the word and raises a one-cycle done pulse with a fault flag. A prescaler parameter gives the number of system cycles per microsecond, and a second parameter gives the half-period of the serial clock.

Top module: `ssi_pos_reader`

## Requirements
- R1: Out of reset `sclk_o` is 1, `done_o` is 0, `fault_o` is 0 and `pos_o` is all zeros.
- R2: When `start_i` is seen in idle, `sclk_o` falls at the next clock edge. A frame then has exactly 25 falling edges of `sclk_o`, and each low and each high phase lasts `HALF_CYC` system cycles.
- R3: The data line is sampled at the clock edge where `sclk_o` falls. The bit taken at the first falling edge becomes bit 23 of the word, and later bits fill the lower positions in order.
- R4: With Gray mode off, `pos_o` equals the 24 sampled bits unchanged.
- R5: With Gray mode on, each stored bit is the XOR of the sampled bit and the previously stored bit, and the first bit is kept as sampled. `gray_i` is captured only on the cycle the frame starts, so later changes have no effect on that frame.
- R6: The bit sampled at the 25th falling edge does not affect `pos_o`.
- R7: `sclk_o` stays high after the 25th rising edge and in idle, until the next accepted start.
- R8: `fault_o` is set if `sdata_i` is 1 at the clock edge exactly `LOW_US*CYC_PER_US` cycles after the 25th rising edge of `sclk_o`.
- R9: `fault_o` is set if `sdata_i` is 0 at the clock edge exactly `HIGH_US*CYC_PER_US` cycles after the 25th rising edge.
- R10: `done_o` is a one-cycle pulse that is visible `HIGH_US*CYC_PER_US` cycles after the 25th rising edge. `pos_o` and `fault_o` change only together with `done_o`, and they are updated even when a fault is reported.
- R11: `start_i` has no effect while a frame or its line check is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that requests a frame |
| gray_i | input | 1 | 1 selects Gray-to-binary conversion for the next frame |
| sdata_i | input | 1 | Serial data from the encoder |
| sclk_o | output | 1 | Serial clock to the encoder, idles high |
| pos_o | output | 24 | Last position word received |
| done_o | output | 1 | One-cycle pulse when a frame and its line check are complete |
| fault_o | output | 1 | Link check result of the last frame, 1 means failure |

## Verification
The hardest situations to reach are the edges of the two post-frame timing windows. A rising data edge one cycle before the short-delay sample must produce a fault, and the same edge one cycle later must not. A rising edge exactly at the long-delay sample must pass. The bench models the encoder as a task that follows `sclk_o` edge by edge and counts system cycles from the final rising edge. That count lets it place the data transition on a chosen cycle, and it covers these boundaries with directed runs. The same task also pulses `start_i` in the middle of a frame and during the check window to show that the block ignores it.

// File: rtl/ssi_reader_pkg.sv
package ssi_reader_pkg;

    // Sequencer phases of the reader
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_CHECK = 2'd2
    } ssi_state_e;

endpackage

// File: rtl/ssi_half_timer.sv
// Counts system cycles while enabled and emits a tick at every half period.
module ssi_half_timer #(
    parameter int HALF_CYC = 25
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == TW'(HALF_CYC - 1));
        cnt_d  = cnt_q;
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // Consecutive ticks would mean a zero-length clock phase
    assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/ssi_shift_gray.sv
// Serial word assembly, MSB first, with optional running Gray decode.
module ssi_shift_gray #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         gray_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o
);
    logic [W-1:0] word_d, word_q;
    logic         next_bit;

    always_comb begin
        // After a clear the last stored bit is 0, so the first bit passes unchanged
        next_bit = gray_i ? (word_q[0] ^ bit_i) : bit_i;
        word_d   = word_q;
        if (clr_i) begin
            word_d = '0;
        end else if (shift_i) begin
            word_d = {word_q[W-2:0], next_bit};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) word_q <= '0;
        else         word_q <= word_d;
    end

    assign word_o = word_q;

    // The sequencer never clears and shifts in one cycle
    assert_clr_shift_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(clr_i && shift_i));

endmodule

// File: rtl/ssi_pos_reader.sv
module ssi_pos_reader
    import ssi_reader_pkg::*;
#(
    parameter int W          = 24,
    parameter int CYC_PER_US = 50,
    parameter int HALF_CYC   = 25,
    parameter int LOW_US     = 5,
    parameter int HIGH_US    = 30
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         gray_i,
    input  logic         sdata_i,
    output logic         sclk_o,
    output logic [W-1:0] pos_o,
    output logic         done_o,
    output logic         fault_o
);
    localparam int LOW_CYC    = LOW_US * CYC_PER_US;
    localparam int HIGH_CYC   = HIGH_US * CYC_PER_US;
    localparam int FRAME_CLKS = W + 1;
    localparam int FW         = $clog2(FRAME_CLKS + 1);
    localparam int CW         = $clog2(HIGH_CYC + 1);

    typedef struct packed {
        ssi_state_e    st;
        logic          sclk;
        logic          smp;
        logic [FW-1:0] falls;
        logic          gsel;
        logic          lowbad;
        logic [CW-1:0] chk;
        logic          done;
        logic          fault;
        logic [W-1:0]  pos;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st: ST_IDLE, sclk: 1'b1, smp: 1'b0, falls: '0, gsel: 1'b0,
        lowbad: 1'b0, chk: '0, done: 1'b0, fault: 1'b0, pos: '0
    };

    regs_t        r_d, r_q;
    logic         tick;
    logic         tmr_run;
    logic         shift_en;
    logic         clr_word;
    logic [W-1:0] word;

    ssi_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (tmr_run),
        .tick_o (tick)
    );

    ssi_shift_gray #(.W(W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_word),
        .shift_i (shift_en),
        .gray_i  (r_q.gsel),
        .bit_i   (r_q.smp),
        .word_o  (word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_run  = (r_q.st == ST_FRAME);
        shift_en = 1'b0;
        clr_word = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    // first falling edge: capture the MSB on this edge
                    r_d.st     = ST_FRAME;
                    r_d.sclk   = 1'b0;
                    r_d.smp    = sdata_i;
                    r_d.falls  = FW'(1);
                    r_d.gsel   = gray_i;
                    r_d.lowbad = 1'b0;
                    clr_word   = 1'b1;
                end
            end
            ST_FRAME: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk = 1'b1;
                        // the power-failure bit (last fall) is not shifted
                        shift_en = (r_q.falls <= FW'(W));
                        if (r_q.falls == FW'(FRAME_CLKS)) begin
                            r_d.st  = ST_CHECK;
                            r_d.chk = '0;
                        end
                    end else begin
                        r_d.sclk  = 1'b0;
                        r_d.smp   = sdata_i;
                        r_d.falls = r_q.falls + 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                r_d.chk = r_q.chk + 1'b1;
                if (r_q.chk == CW'(LOW_CYC - 1) && sdata_i) begin
                    r_d.lowbad = 1'b1;
                end
                if (r_q.chk == CW'(HIGH_CYC - 1)) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fault = r_q.lowbad | ~sdata_i;
                    r_d.pos   = word;
                end
            end
            default: r_d = REGS_RST;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= REGS_RST;
        else         r_q <= r_d;
    end

    assign sclk_o  = r_q.sclk;
    assign pos_o   = r_q.pos;
    assign done_o  = r_q.done;
    assign fault_o = r_q.fault;

    assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(fault_o));

    assert_pos_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(pos_o));

    assert_sclk_parked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st != ST_FRAME) |-> sclk_o);

    assert_frame_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.falls <= FW'(FRAME_CLKS));

    assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_CHECK && start_i) |=> (r_q.st != ST_FRAME));

endmodule

// File: tb/ssi_pos_reader_test.sv
module ssi_pos_reader_test;

    localparam int W     = 24;
    localparam int CPU   = 50;
    localparam int HALF  = 10;
    localparam int LOW_C = 5 * CPU;
    localparam int HIGH_C = 30 * CPU;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         gsel = 1'b0;
    logic         sdata = 1'b1;
    logic         sclk;
    logic [W-1:0] pos;
    logic         done;
    logic         fault;

    int n_checks = 0;
    int n_fail   = 0;
    int falls_seen = 0;
    int cur_low = 0;
    int last_low = 0;
    int cur_high = 0;
    int last_high = 0;

    always #10 clk = ~clk;   // 50 MHz

    ssi_pos_reader #(
        .W(W), .CYC_PER_US(CPU), .HALF_CYC(HALF), .LOW_US(5), .HIGH_US(30)
    ) uut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .gray_i(gsel),
        .sdata_i(sdata), .sclk_o(sclk), .pos_o(pos), .done_o(done), .fault_o(fault)
    );

    // Passive monitors of the serial clock
    always @(negedge sclk) falls_seen++;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!sclk) begin
                cur_low++;
                if (cur_high != 0) begin last_high = cur_high; cur_high = 0; end
            end else begin
                if (cur_low != 0) begin last_low = cur_low; cur_low = 0; end
                if (falls_seen > 0 && falls_seen < 25) cur_high++;
            end
        end
    end

    function automatic logic [W-1:0] gray2bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    // mode 0: data low then high at post-rise cycle c; 1: stays high; 2: stays low
    task automatic run_frame(input logic [W-1:0] word, input logic pfb, input logic g,
                             input int mode, input int c, input logic poke);
        logic [W-1:0] exp_pos;
        logic         exp_fault;
        int           cyc;
        logic         seen;
        exp_pos   = g ? gray2bin(word) : word;
        exp_fault = (mode != 0) || (c <= LOW_C) || (c > HIGH_C);
        @(negedge clk);
        sdata = word[W-1];
        gsel  = g;
        falls_seen = 0;
        last_high = 0;
        cur_high = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        gsel  = ~g;          // must not matter after the frame started (R5)
        check("R2 sclk falls after start", {31'd0, sclk}, 32'd0);
        for (int i = 0; i < 25; i++) begin
            @(posedge sclk);
            @(negedge clk);
            if (i < 23)       sdata = word[W-2-i];
            else if (i == 23) sdata = pfb;
            else              sdata = (mode == 1);
            if (i == 10 && poke) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        end
        // first negedge after the final rise has been consumed: cyc = 1
        cyc  = 1;
        seen = 1'b0;
        while (!seen && cyc < 3 * HIGH_C) begin
            @(negedge clk);
            cyc++;
            if (mode == 0 && cyc == c) sdata = 1'b1;
            if (poke && cyc == 5) start = 1'b1;
            if (poke && cyc == 6) start = 1'b0;
            if (done) seen = 1'b1;
        end
        check("R10 done latency", cyc, HIGH_C + 1);
        check("R2 falling edges per frame", falls_seen, 25);
        check("R2 low phase length", last_low, HALF);
        check("R2 high phase length", last_high, HALF);
        check(g ? "R5 gray decoded word" : "R4 binary word", {8'd0, pos}, {8'd0, exp_pos});
        check(mode == 1 ? "R8 fault" : "R9 fault", {31'd0, fault}, {31'd0, exp_fault});
        @(negedge clk);
        check("R10 done one cycle", {31'd0, done}, 32'd0);
        repeat (5) @(negedge clk);
        check("R7 sclk parked high", {31'd0, sclk}, 32'd1);
        check("R10 fault held", {31'd0, fault}, {31'd0, exp_fault});
        check("R11 no restart", falls_seen, 25);
        sdata = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5511));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 sclk after reset", {31'd0, sclk}, 32'd1);
        check("R1 done after reset", {31'd0, done}, 32'd0);
        check("R1 fault after reset", {31'd0, fault}, 32'd0);
        check("R1 pos after reset", {8'd0, pos}, 32'd0);

        // R3: asymmetric pattern exposes bit order
        run_frame(24'hA5C30F, 1'b0, 1'b0, 0, 600, 1'b0);
        run_frame(24'h000001, 1'b1, 1'b0, 0, 600, 1'b0);
        run_frame(24'h800000, 1'b0, 1'b1, 0, 700, 1'b0);
        run_frame(24'hFFFFFF, 1'b0, 1'b1, 0, 700, 1'b0);
        // R6: same word, opposite trailing bit
        run_frame(24'h3C5A96, 1'b0, 1'b0, 0, 800, 1'b0);
        run_frame(24'h3C5A96, 1'b1, 1'b0, 0, 800, 1'b0);
        // R8 window edges
        run_frame(24'h123456, 1'b0, 1'b0, 0, LOW_C, 1'b0);
        run_frame(24'h654321, 1'b0, 1'b0, 0, LOW_C + 1, 1'b0);
        // R9 window edge and missing recovery
        run_frame(24'h0F0F0F, 1'b1, 1'b1, 0, HIGH_C, 1'b0);
        run_frame(24'hF0F0F0, 1'b0, 1'b0, 2, 0, 1'b0);
        run_frame(24'h777777, 1'b0, 1'b1, 1, 0, 1'b0);
        // R11: starts during frame and during the check window
        run_frame(24'hC0FFEE, 1'b1, 1'b0, 0, 900, 1'b1);
        run_frame(24'hBADA55, 1'b0, 1'b1, 0, 900, 1'b1);

        for (int k = 0; k < 28; k++) begin
            logic [W-1:0] w;
            int           m;
            int           c;
            w = W'($urandom);
            m = ($urandom % 8 == 0) ? int'(1 + $urandom % 2) : 0;
            c = LOW_C + 1 + int'($urandom % (HIGH_C - LOW_C));
            run_frame(w, 1'($urandom), 1'($urandom), m, c, 1'($urandom % 4 == 0));
        end
        summary();
    end

endmodule